// File: doc/BRIEF.md
# JTAG TAP Instruction Register

This block holds the instruction register of a JTAG test access port, together with the sixteen-state controller that sequences it. The controller advances on the rising edge of the test clock and follows the standard IEEE 1149.1 transition graph. The register has three parts: a shift stage that captures and shifts, a latched current instruction, and a serial output flop that feeds the port's TDO multiplexer.

A fixed pattern is captured into the shift stage and shifted out through the serial output. New instruction bits enter from the serial input and move one place toward the LSB on each shift. The latched instruction is loaded on the falling clock edge, and only in the update-instruction state or the reset state. Reset loads the identification opcode in two ways: through the mode-select sequence on a falling edge, or at once when the asynchronous reset pin is driven low.

Decoded state strobes for both the instruction and the data columns are exported. A data-register block can use them to capture, shift and update its own registers.

Top module: `tap_ir_top`

## Requirements
- R1: The controller updates its state on the rising edge of `tck` according to the IEEE 1149.1 graph. Each `st_*` output is high exactly while the controller is in its state (reset, capture/shift/update of IR, capture/shift/update of DR).
- R2: Five consecutive rising edges with `tms`=1 bring the controller to the reset state from any state.
- R3: A rising edge in the capture-IR state loads 6'b000001 into the shift stage. The first bit presented on `ir_so` in shift-IR is therefore 1, and the next five are 0.
- R4: A rising edge in the shift-IR state moves the shift stage one place toward bit 0, with `tdi` entering bit 5. On each falling edge while in shift-IR, `ir_so` takes bit 0 of the shift stage. In every other state `ir_so` holds its value.
- R5: On the falling edge of `tck` in the update-IR state, `ir_cur` takes the contents of the shift stage. The BYPASS opcode is 6'b111111.
- R6: `ir_cur` does not change in any state other than update-IR and reset.
- R7: On the falling edge of `tck` in the reset state, `ir_cur` takes the identification opcode 6'b000001.
- R8: While `trst_n` is low, and with no clock edge needed, `ir_cur` is 6'b000001, the controller is in the reset state, and `ir_so` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data input |
| ir_so | output | 1 | Registered serial output of the instruction shift stage |
| ir_cur | output | 6 | Latched current instruction |
| st_tlr | output | 1 | Controller is in the reset state |
| st_cap_ir | output | 1 | Controller is in capture-IR |
| st_sh_ir | output | 1 | Controller is in shift-IR |
| st_upd_ir | output | 1 | Controller is in update-IR |
| st_cap_dr | output | 1 | Controller is in capture-DR |
| st_sh_dr | output | 1 | Controller is in shift-DR |
| st_upd_dr | output | 1 | Controller is in update-DR |

## Verification
Directed sequences come first. They shift the BYPASS opcode in and read the captured pattern out, which separates the capture value from stale register contents and from the input bits. They walk the DR column with a loaded instruction to show that it holds. They reach reset from shift-DR with five `tms` ones, and the fourth step shows that nothing changes before reset is reached. They pull `trst_n` low while the clock is high, to tell the asynchronous load apart from the edge-timed one. A long run of random `tms`/`tdi` with occasional resets then compares every strobe, `ir_so` and `ir_cur` against a bench model, cycle by cycle.

// File: rtl/tap_ir_pkg.sv
package tap_ir_pkg;

    localparam int IR_W = 6;

    localparam logic [IR_W-1:0] OP_IDCODE   = IR_W'(1);
    localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(1);

    typedef enum logic [3:0] {
        S_RESET, S_IDLE,
        S_SEL_DR, S_CAP_DR, S_SH_DR, S_EX1_DR, S_PAU_DR, S_EX2_DR, S_UPD_DR,
        S_SEL_IR, S_CAP_IR, S_SH_IR, S_EX1_IR, S_PAU_IR, S_EX2_IR, S_UPD_IR
    } tap_state_e;

    typedef struct packed {
        logic tlr;
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
        logic cap_dr;
        logic sh_dr;
        logic upd_dr;
    } tap_strobe_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        case (s)
            S_RESET:  n = tms ? S_RESET  : S_IDLE;
            S_IDLE:   n = tms ? S_SEL_DR : S_IDLE;
            S_SEL_DR: n = tms ? S_SEL_IR : S_CAP_DR;
            S_CAP_DR: n = tms ? S_EX1_DR : S_SH_DR;
            S_SH_DR:  n = tms ? S_EX1_DR : S_SH_DR;
            S_EX1_DR: n = tms ? S_UPD_DR : S_PAU_DR;
            S_PAU_DR: n = tms ? S_EX2_DR : S_PAU_DR;
            S_EX2_DR: n = tms ? S_UPD_DR : S_SH_DR;
            S_UPD_DR: n = tms ? S_SEL_DR : S_IDLE;
            S_SEL_IR: n = tms ? S_RESET  : S_CAP_IR;
            S_CAP_IR: n = tms ? S_EX1_IR : S_SH_IR;
            S_SH_IR:  n = tms ? S_EX1_IR : S_SH_IR;
            S_EX1_IR: n = tms ? S_UPD_IR : S_PAU_IR;
            S_PAU_IR: n = tms ? S_EX2_IR : S_PAU_IR;
            S_EX2_IR: n = tms ? S_UPD_IR : S_SH_IR;
            S_UPD_IR: n = tms ? S_SEL_DR : S_IDLE;
            default:  n = S_RESET;
        endcase
        return n;
    endfunction

    function automatic tap_strobe_t tap_decode(tap_state_e s);
        tap_strobe_t d;
        d.tlr    = (s == S_RESET);
        d.cap_ir = (s == S_CAP_IR);
        d.sh_ir  = (s == S_SH_IR);
        d.upd_ir = (s == S_UPD_IR);
        d.cap_dr = (s == S_CAP_DR);
        d.sh_dr  = (s == S_SH_DR);
        d.upd_dr = (s == S_UPD_DR);
        return d;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_ir_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state_o
);

    tap_state_e state_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state_q <= S_RESET;
        else         state_q <= tap_next(state_q, tms);
    end

    assign state_o = state_q;

    // R1: leaving reset with tms low lands in run-test/idle
    assert_tlr_exit_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == S_RESET && !tms) |=> (state_q == S_IDLE));

    // R1: select-IR with tms low enters capture-IR
    assert_sel_ir_R1: assert property (@(posedge tck) disable iff (!trst_n)
        (state_q == S_SEL_IR && !tms) |=> (state_q == S_CAP_IR));

    assert_five_ones_R2: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms, 1) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
        |=> (state_q == S_RESET));

endmodule

// File: rtl/ir_shift.sv
module ir_shift
    import tap_ir_pkg::*;
#(
    parameter int W = IR_W
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tdi,
    input  tap_state_e   state_i,
    output logic [W-1:0] sr_o,
    output logic         so_o
);

    localparam logic [W-1:0] CAP_VAL = W'(CAPTURE_PAT);

    logic [W-1:0] sr_q;
    logic         so_q;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            sr_q <= CAP_VAL;
        end else begin
            case (state_i)
                S_CAP_IR: sr_q <= CAP_VAL;
                S_SH_IR:  sr_q <= {tdi, sr_q[W-1:1]};
                default:  sr_q <= sr_q;
            endcase
        end
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                so_q <= 1'b0;
        else if (state_i == S_SH_IR) so_q <= sr_q[0];
    end

    assign sr_o = sr_q;
    assign so_o = so_q;

    assert_capture_R3: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == S_CAP_IR) |=> (sr_q == CAP_VAL));

    assert_shift_R4: assert property (@(posedge tck) disable iff (!trst_n)
        (state_i == S_SH_IR) |=> (sr_q == {$past(tdi), $past(sr_q[W-1:1])}));

    assert_serial_out_R4: assert property (@(negedge tck) disable iff (!trst_n)
        (state_i == S_SH_IR) |=> (so_q == $past(sr_q[0])));

endmodule

// File: rtl/ir_hold.sv
module ir_hold
    import tap_ir_pkg::*;
#(
    parameter int W = IR_W
) (
    input  logic         tck,
    input  logic         trst_n,
    input  tap_state_e   state_i,
    input  logic [W-1:0] sr_i,
    output logic [W-1:0] cur_o
);

    localparam logic [W-1:0] ID_VAL = W'(OP_IDCODE);

    logic [W-1:0] cur_q;

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)                  cur_q <= ID_VAL;
        else if (state_i == S_RESET)  cur_q <= ID_VAL;
        else if (state_i == S_UPD_IR) cur_q <= sr_i;
    end

    assign cur_o = cur_q;

    assert_update_R5: assert property (@(negedge tck) disable iff (!trst_n)
        (state_i == S_UPD_IR) |=> (cur_q == $past(sr_i)));

    assert_hold_R6: assert property (@(negedge tck) disable iff (!trst_n)
        (state_i != S_UPD_IR && state_i != S_RESET) |=> $stable(cur_q));

    assert_tlr_idcode_R7: assert property (@(negedge tck) disable iff (!trst_n)
        (state_i == S_RESET) |=> (cur_q == ID_VAL));

endmodule

// File: rtl/tap_ir_top.sv
module tap_ir_top
    import tap_ir_pkg::*;
#(
    parameter int W = IR_W
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tms,
    input  logic         tdi,
    output logic         ir_so,
    output logic [W-1:0] ir_cur,
    output logic         st_tlr,
    output logic         st_cap_ir,
    output logic         st_sh_ir,
    output logic         st_upd_ir,
    output logic         st_cap_dr,
    output logic         st_sh_dr,
    output logic         st_upd_dr
);

    tap_state_e   state;
    tap_strobe_t  strb;
    logic [W-1:0] sr;

    tap_fsm u_fsm (
        .tck     (tck),
        .trst_n  (trst_n),
        .tms     (tms),
        .state_o (state)
    );

    ir_shift #(.W(W)) u_shift (
        .tck     (tck),
        .trst_n  (trst_n),
        .tdi     (tdi),
        .state_i (state),
        .sr_o    (sr),
        .so_o    (ir_so)
    );

    ir_hold #(.W(W)) u_hold (
        .tck     (tck),
        .trst_n  (trst_n),
        .state_i (state),
        .sr_i    (sr),
        .cur_o   (ir_cur)
    );

    assign strb      = tap_decode(state);
    assign st_tlr    = strb.tlr;
    assign st_cap_ir = strb.cap_ir;
    assign st_sh_ir  = strb.sh_ir;
    assign st_upd_ir = strb.upd_ir;
    assign st_cap_dr = strb.cap_dr;
    assign st_sh_dr  = strb.sh_dr;
    assign st_upd_dr = strb.upd_dr;

endmodule

// File: tb/test_tap_ir_top.sv
`timescale 1ns/1ps
module test_tap_ir_top;

    // bench-side state numbering, independent of the design
    localparam int M_RST = 0,  M_IDLE = 1,
                   M_SDR = 2,  M_CDR = 3,  M_SHDR = 4,  M_E1DR = 5,
                   M_PDR = 6,  M_E2DR = 7, M_UDR = 8,
                   M_SIR = 9,  M_CIR = 10, M_SHIR = 11, M_E1IR = 12,
                   M_PIR = 13, M_E2IR = 14, M_UIR = 15;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tms = 1'b1;
    logic       tdi = 1'b0;
    logic       ir_so;
    logic [5:0] ir_cur;
    logic       st_tlr, st_cap_ir, st_sh_ir, st_upd_ir, st_cap_dr, st_sh_dr, st_upd_dr;

    int         n_chk = 0;
    int         n_bad = 0;
    int         mst;
    logic [5:0] msr;
    logic [5:0] mcur;
    logic       mso;

    always #2.5 tck = ~tck;

    tap_ir_top i_tap_ir_top (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
        .ir_so(ir_so), .ir_cur(ir_cur),
        .st_tlr(st_tlr), .st_cap_ir(st_cap_ir), .st_sh_ir(st_sh_ir), .st_upd_ir(st_upd_ir),
        .st_cap_dr(st_cap_dr), .st_sh_dr(st_sh_dr), .st_upd_dr(st_upd_dr)
    );

    function automatic int nxt(int s, bit t);
        case (s)
            M_RST:  return t ? M_RST  : M_IDLE;
            M_IDLE: return t ? M_SDR  : M_IDLE;
            M_SDR:  return t ? M_SIR  : M_CDR;
            M_CDR:  return t ? M_E1DR : M_SHDR;
            M_SHDR: return t ? M_E1DR : M_SHDR;
            M_E1DR: return t ? M_UDR  : M_PDR;
            M_PDR:  return t ? M_E2DR : M_PDR;
            M_E2DR: return t ? M_UDR  : M_SHDR;
            M_UDR:  return t ? M_SDR  : M_IDLE;
            M_SIR:  return t ? M_RST  : M_CIR;
            M_CIR:  return t ? M_E1IR : M_SHIR;
            M_SHIR: return t ? M_E1IR : M_SHIR;
            M_E1IR: return t ? M_UIR  : M_PIR;
            M_PIR:  return t ? M_E2IR : M_PIR;
            M_E2IR: return t ? M_UIR  : M_SHIR;
            default: return t ? M_SDR  : M_IDLE;
        endcase
    endfunction

    function automatic logic [6:0] exp_strobes(int s);
        return {s == M_RST, s == M_CIR, s == M_SHIR, s == M_UIR,
                s == M_CDR, s == M_SHDR, s == M_UDR};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        logic [6:0] s;
        s = {st_tlr, st_cap_ir, st_sh_ir, st_upd_ir, st_cap_dr, st_sh_dr, st_upd_dr};
        chk(s == exp_strobes(mst), "R1 R2 strobes", 32'(s), 32'(exp_strobes(mst)));
        chk(ir_so == mso, "R3 R4 ir_so", 32'(ir_so), 32'(mso));
        chk(ir_cur == mcur, "R5 R6 R7 ir_cur", 32'(ir_cur), 32'(mcur));
    endtask

    task automatic model_reset();
        mst = M_RST; msr = 6'b000001; mcur = 6'b000001; mso = 1'b0;
    endtask

    // called just after a falling edge; returns just after the next falling edge
    task automatic step(input bit t, input bit d);
        tms = t; tdi = d;
        @(posedge tck); #1;
        if (mst == M_CIR)       msr = 6'b000001;
        else if (mst == M_SHIR) msr = {d, msr[5:1]};
        mst = nxt(mst, t);
        @(negedge tck); #1;
        if (mst == M_SHIR)     mso = msr[0];
        if (mst == M_UIR)      mcur = msr;
        else if (mst == M_RST) mcur = 6'b000001;
        compare_all();
    endtask

    task automatic load_ir(input logic [5:0] op);
        step(1'b0, 1'b0);   // to run-test/idle (or stay)
        step(1'b1, 1'b0);   // select-DR
        step(1'b1, 1'b0);   // select-IR
        step(1'b0, 1'b0);   // capture-IR
        step(1'b0, 1'b0);   // shift-IR
        for (int i = 0; i < 5; i++) step(1'b0, op[i]);
        step(1'b1, op[5]);  // exit1-IR
        step(1'b1, 1'b0);   // update-IR
        step(1'b0, 1'b0);   // idle
    endtask

    task automatic finish_up();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        @(negedge tck); #1;
        // R8: values while trst_n is held low
        chk(ir_cur == 6'b000001, "R8 reset ir_cur", 32'(ir_cur), 32'h01);
        chk(st_tlr == 1'b1, "R8 reset state", 32'(st_tlr), 32'h1);
        chk(ir_so == 1'b0, "R8 reset ir_so", 32'(ir_so), 32'h0);
        trst_n = 1'b1;

        // R3: captured pattern read out first in shift-IR
        step(1'b0, 1'b0); step(1'b1, 1'b0); step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        chk(ir_so == 1'b1, "R3 first bit", 32'(ir_so), 32'h1);
        for (int i = 0; i < 5; i++) begin
            step(1'b0, 1'b1);
            chk(ir_so == 1'b0, "R3 R4 following bits", 32'(ir_so), 32'h0);
        end
        step(1'b1, 1'b1);
        chk(ir_cur == 6'b000001, "R6 exit1 no change", 32'(ir_cur), 32'h01);
        step(1'b1, 1'b0);
        chk(ir_cur == 6'b111111, "R5 update BYPASS", 32'(ir_cur), 32'h3F);

        // R6: walk the DR column, instruction held
        step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b1);
        step(1'b0, 1'b0); step(1'b1, 1'b1); step(1'b0, 1'b0);
        chk(ir_cur == 6'b111111, "R6 hold in DR column", 32'(ir_cur), 32'h3F);

        // R2 R7: five ones from shift-DR
        step(1'b1, 1'b0); step(1'b0, 1'b0);   // exit2-DR -> shift-DR
        chk(st_sh_dr == 1'b1, "R1 in shift-DR", 32'(st_sh_dr), 32'h1);
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0);
        chk(ir_cur == 6'b111111 && !st_tlr, "R2 R6 four ones not yet reset",
            32'(ir_cur), 32'h3F);
        step(1'b1, 1'b0);
        chk(st_tlr == 1'b1, "R2 five ones reach reset", 32'(st_tlr), 32'h1);
        chk(ir_cur == 6'b000001, "R7 sync IDCODE", 32'(ir_cur), 32'h01);

        // R5: a non-trivial opcode, bit order check
        load_ir(6'b101100);
        chk(ir_cur == 6'b101100, "R4 R5 opcode bit order", 32'(ir_cur), 32'h2C);

        // R8: asynchronous reset while tck is high
        tms = 1'b0;
        @(posedge tck); #1;
        trst_n = 1'b0;
        #0.5;
        chk(ir_cur == 6'b000001, "R8 async IDCODE", 32'(ir_cur), 32'h01);
        chk(st_tlr == 1'b1, "R8 async state", 32'(st_tlr), 32'h1);
        model_reset();
        @(negedge tck); #1;
        trst_n = 1'b1;

        // random phase
        for (int k = 0; k < 3000; k++) begin
            if (($urandom % 200) == 0) begin
                trst_n = 1'b0;
                #0.5;
                model_reset();
                chk(ir_cur == 6'b000001 && st_tlr, "R8 random async", 32'(ir_cur), 32'h01);
                @(negedge tck); #1;
                trst_n = 1'b1;
            end else begin
                step(1'($urandom % 2), 1'($urandom % 2));
            end
        end
        finish_up();
    end

endmodule